// File: doc/BRIEF.md
# Flash Write-Protect Range Gate

This block guards the high-voltage enable of an on-chip flash controller. It keeps a block-protect register on a simple CPU register bus. The register's writable field sets a protection start address, and the protected range runs from that address to the highest address in the map. The CPU asks to turn on the high-voltage enable for an erase or a program operation at some target flash address. The gate grants the request only when that target lies below the protected range. A refused request leaves the enable low and raises a one-cycle violation pulse.

The register field is FIELD_W = ADDR_W - PROT_LSB bits wide. It supplies the upper address bits of the start address, and the low PROT_LSB bits of the start are zero. With the default parameters the register sits at CPU address 16'hFE08. Data bits [7:1] hold address bits [15:9], and data bit 0 is unimplemented. The charge pump, array timing and erase sequencing sit outside this block.

Top module: `flash_prot_gate`

## Requirements
- R1: After reset the register field is all zero, `reg_rdata` is 0, and `hv_en` and `prot_violation` are 0. A zero field places the start at address 0, so every address is protected.
- R2: A write with `reg_wr` high and `reg_addr` equal to REG_ADDR stores `reg_wdata[FIELD_W:1]` at the next clock edge. A read of REG_ADDR with `reg_rd` high returns the field in bits [FIELD_W:1]. Bit 0 of that read always returns 0, whatever was written to it.
- R3: A read of any other address, or with `reg_rd` low, returns 0. A write to any other address leaves the register unchanged.
- R4: The start address is the field shifted left by PROT_LSB. A target address is protected when, as an unsigned number, it is greater than or equal to the start. This includes the all-ones top address.
- R5: A request (`hv_set` high, `hv_clr` low) for an unprotected target sets `hv_en` at the next edge. At that edge `hv_op_erase` latches `hv_erase` (1 = erase, 0 = program).
- R6: A request for a protected target leaves `hv_en` low at the next edge, in both erase and program mode. It also drives `prot_violation` high for exactly one cycle, which then falls unless another refused request follows.
- R7: When a register write and a request fall in the same cycle, the request is judged against the old register value.
- R8: While `hv_en` is high and the target becomes protected (for example through a register write), `hv_en` clears at the next edge. After a register write this is the second edge after the write strobe.
- R9: `hv_clr` clears `hv_en` at the next edge and takes priority over `hv_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | CPU register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, 0 when not selected |
| hv_set | input | 1 | Request to set the high-voltage enable |
| hv_clr | input | 1 | Request to clear the high-voltage enable |
| hv_erase | input | 1 | Mode of the request: 1 erase, 0 program |
| flash_addr | input | ADDR_W | Target flash address of the operation |
| hv_en | output | 1 | Gated high-voltage enable |
| hv_op_erase | output | 1 | Mode latched when the enable was granted |
| prot_violation | output | 1 | One-cycle pulse for a refused request |

## Verification
The bench builds the gate with ADDR_W = 10, PROT_LSB = 3 and DATA_W = 8. This keeps the 7-bit field of the default build but shrinks the address map to 1024 locations. With that map, all 128 field values can be swept against the addresses just below, at and above each start address and at both ends of the map. A few field values, including zero and the all-ones field, are also crossed with every one of the 1024 target addresses in both modes. Against these sweeps the bench checks the protection decision, the one-cycle violation pulse, write-versus-request ordering and the revoke timing, all computed arithmetically in the bench.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic {
    HV_PROGRAM = 1'b0,
    HV_ERASE   = 1'b1
  } hv_mode_e;
endpackage

// File: rtl/fwp_bp_reg.sv
module fwp_bp_reg #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          PROT_LSB = 9,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE08
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [ADDR_W-PROT_LSB-1:0]    field,
  output logic [DATA_W-1:0]             reg_rdata
);
  localparam int FIELD_W = ADDR_W - PROT_LSB;

  logic                  sel;
  logic                  wr_hit;
  logic                  rd_hit;
  logic [FIELD_W-1:0]    field_q;

  assign sel    = (reg_addr == REG_ADDR);
  assign wr_hit = reg_wr && sel;
  assign rd_hit = reg_rd && sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      field_q <= '0;
    else if (wr_hit) field_q <= reg_wdata[FIELD_W:1];
  end

  always_comb begin
    reg_rdata = '0;
    if (rd_hit) reg_rdata[FIELD_W:1] = field_q;
  end

  assign field = field_q;

  assert_write_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> field_q == $past(reg_wdata[FIELD_W:1]));

  assert_bit0_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> reg_rdata[0] == 1'b0);

  assert_other_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(field_q));

  assert_miss_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> reg_rdata == '0);
endmodule

// File: rtl/fwp_range_chk.sv
module fwp_range_chk #(
  parameter int ADDR_W   = 16,
  parameter int PROT_LSB = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-PROT_LSB-1:0]  field,
  input  logic [ADDR_W-1:0]           target,
  output logic [ADDR_W-1:0]           start_addr,
  output logic                        prot_hit
);
  localparam int FIELD_W = ADDR_W - PROT_LSB;

  function automatic logic [ADDR_W-1:0] calc_start(input logic [FIELD_W-1:0] f);
    calc_start = {f, {PROT_LSB{1'b0}}};
  endfunction

  function automatic logic in_range(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] s);
    in_range = (a >= s);
  endfunction

  assign start_addr = calc_start(field);
  assign prot_hit   = in_range(target, start_addr);

  assert_upper_compare_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit == (target[ADDR_W-1:PROT_LSB] >= field));

  assert_top_protected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&target) |-> prot_hit);

  assert_zero_field_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (field == '0) |-> prot_hit);
endmodule

// File: rtl/fwp_hv_gate.sv
module fwp_hv_gate
  import fwp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hv_set,
  input  logic     hv_clr,
  input  hv_mode_e hv_mode,
  input  logic     prot_hit,
  output logic     hv_en,
  output logic     hv_op_erase,
  output logic     violation
);
  logic     grant;
  logic     refuse;
  logic     revoke;
  logic     en_q;
  logic     viol_q;
  hv_mode_e op_q;

  assign grant  = hv_set && !hv_clr && !prot_hit;
  assign refuse = hv_set && prot_hit;
  assign revoke = en_q && prot_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      viol_q <= 1'b0;
      op_q   <= HV_PROGRAM;
    end else begin
      viol_q <= refuse;
      if (hv_clr)      en_q <= 1'b0;
      else if (hv_set) en_q <= !prot_hit;
      else if (revoke) en_q <= 1'b0;
      if (grant) op_q <= hv_mode;
    end
  end

  assign hv_en       = en_q;
  assign hv_op_erase = (op_q == HV_ERASE);
  assign violation   = viol_q;

  assert_grant_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> hv_en && (hv_op_erase == ($past(hv_mode) == HV_ERASE)));

  assert_refuse_holds_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> !hv_en && violation);

  assert_violation_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> $past(refuse));

  assert_revoke_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (revoke && !hv_set) |=> !hv_en);

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hv_clr |=> !hv_en);
endmodule

// File: rtl/flash_prot_gate.sv
module flash_prot_gate
  import fwp_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          PROT_LSB = 9,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              hv_set,
  input  logic              hv_clr,
  input  logic              hv_erase,
  input  logic [ADDR_W-1:0] flash_addr,
  output logic              hv_en,
  output logic              hv_op_erase,
  output logic              prot_violation
);
  localparam int FIELD_W = ADDR_W - PROT_LSB;

  logic [FIELD_W-1:0] field;
  logic [ADDR_W-1:0]  start_addr;
  logic               prot_hit;
  hv_mode_e           mode;

  assign mode = hv_mode_e'(hv_erase);

  fwp_bp_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_LSB(PROT_LSB), .REG_ADDR(REG_ADDR)
  ) reg_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .field(field), .reg_rdata(reg_rdata)
  );

  fwp_range_chk #(
    .ADDR_W(ADDR_W), .PROT_LSB(PROT_LSB)
  ) chk_i (
    .clk(clk), .rst_n(rst_n), .field(field), .target(flash_addr),
    .start_addr(start_addr), .prot_hit(prot_hit)
  );

  fwp_hv_gate gate_i (
    .clk(clk), .rst_n(rst_n), .hv_set(hv_set), .hv_clr(hv_clr),
    .hv_mode(mode), .prot_hit(prot_hit),
    .hv_en(hv_en), .hv_op_erase(hv_op_erase), .violation(prot_violation)
  );

  assert_start_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_addr[PROT_LSB-1:0] == '0);

  assert_old_value_used_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_set && !hv_clr && !prot_hit && reg_wr && reg_addr == REG_ADDR) |=> hv_en);
endmodule

// File: tb/flash_prot_gate_tb_top.sv
module flash_prot_gate_tb_top;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 8;
  localparam int PROT_LSB = 3;
  localparam int FIELD_W  = ADDR_W - PROT_LSB;
  localparam int NFIELD   = 1 << FIELD_W;
  localparam int NADDR    = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] RADDR = 10'h208;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              hv_set = 1'b0, hv_clr = 1'b0, hv_erase = 1'b0;
  logic [ADDR_W-1:0] flash_addr = '0;
  logic              hv_en, hv_op_erase, prot_violation;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_prot_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_LSB(PROT_LSB), .REG_ADDR(RADDR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hv_set(hv_set), .hv_clr(hv_clr), .hv_erase(hv_erase),
    .flash_addr(flash_addr), .hv_en(hv_en), .hv_op_erase(hv_op_erase),
    .prot_violation(prot_violation)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int prot_of(input int f, input int a);
    return (a >= f * (1 << PROT_LSB)) ? 1 : 0;
  endfunction

  task automatic wr_reg(input int f, input int addr);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = addr[ADDR_W-1:0];
    reg_wdata = DATA_W'((f << 1) | 1);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int addr, input int exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = addr[ADDR_W-1:0];
    #1 chk(req, int'(reg_rdata), exp);
    reg_rd = 1'b0;
  endtask

  // one request after a clear; checks grant or refusal and the pulse length
  task automatic try_req(input int f, input int tgt, input bit erase, input bit pulse_chk);
    int p;
    p = prot_of(f, tgt);
    @(negedge clk);
    hv_clr = 1'b1;
    @(negedge clk);
    hv_clr = 1'b0; hv_set = 1'b1; flash_addr = tgt[ADDR_W-1:0]; hv_erase = erase;
    @(negedge clk);
    hv_set = 1'b0;
    chk(p ? "R6 hv_en" : "R5 hv_en", int'(hv_en), 1 - p);
    chk("R6 violation", int'(prot_violation), p);
    if (!p) chk("R5 mode", int'(hv_op_erase), int'(erase));
    if (pulse_chk) begin
      @(negedge clk);
      chk("R6 pulse one cycle", int'(prot_violation), 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hv_en", int'(hv_en), 0);
    chk("R1 violation", int'(prot_violation), 0);
    rst_n = 1'b1;
    rd_chk("R1 reg reset", int'(RADDR), 0);
    try_req(0, 0, 1'b0, 1'b1);          // R1: all protected after reset
    try_req(0, NADDR - 1, 1'b1, 1'b0);

    // R2 write/read, bit0 dropped
    wr_reg(7'h55, int'(RADDR));
    rd_chk("R2 readback", int'(RADDR), 7'h55 << 1);
    wr_reg(NFIELD - 1, int'(RADDR));
    rd_chk("R2 all ones bit0 zero", int'(RADDR), (NFIELD - 1) << 1);

    // R3 other addresses
    wr_reg(7'h12, int'(RADDR) + 1);
    wr_reg(7'h12, 0);
    rd_chk("R3 foreign write ignored", int'(RADDR), (NFIELD - 1) << 1);
    rd_chk("R3 foreign read zero", int'(RADDR) - 1, 0);
    rd_chk("R3 foreign read zero", NADDR - 1, 0);
    @(negedge clk);
    reg_addr = RADDR; reg_rd = 1'b0;
    #1 chk("R3 no read strobe zero", int'(reg_rdata), 0);

    // R4/R5/R6 sweep of every field value at range edges
    for (int f = 0; f < NFIELD; f++) begin
      int s;
      s = f * (1 << PROT_LSB);
      wr_reg(f, int'(RADDR));
      try_req(f, (s > 0) ? s - 1 : 0, f[0], 1'b0);
      try_req(f, s, ~f[0], 1'b0);
      try_req(f, (s + 1) % NADDR, f[1], 1'b0);
      try_req(f, NADDR - 1, f[2], 1'b0);
      try_req(f, 0, 1'b1, 1'b0);
      try_req(f, (f * 37 + 11) % NADDR, 1'b0, 1'b1);
    end

    // R4 exhaustive targets for selected fields
    for (int k = 0; k < 4; k++) begin
      int f;
      f = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? NFIELD / 2 : NFIELD - 1;
      wr_reg(f, int'(RADDR));
      for (int a = 0; a < NADDR; a++) try_req(f, a, a[0], 1'b0);
    end

    // R7 same-cycle write uses old value: old unprotects, new protects
    wr_reg(NFIELD - 1, int'(RADDR));
    @(negedge clk); hv_clr = 1'b1;
    @(negedge clk);
    hv_clr = 1'b0; hv_set = 1'b1; flash_addr = 10'd16; hv_erase = 1'b1;
    reg_wr = 1'b1; reg_addr = RADDR; reg_wdata = 8'd0;
    @(negedge clk);
    hv_set = 1'b0; reg_wr = 1'b0;
    chk("R7 old value grants", int'(hv_en), 1);
    chk("R7 no violation", int'(prot_violation), 0);
    @(negedge clk);
    chk("R8 revoke after write", int'(hv_en), 0);

    // R7 reverse: old protects, new unprotects
    @(negedge clk); hv_clr = 1'b1;
    @(negedge clk);
    hv_clr = 1'b0; hv_set = 1'b1; flash_addr = 10'd16;
    reg_wr = 1'b1; reg_addr = RADDR; reg_wdata = DATA_W'((NFIELD - 1) << 1);
    @(negedge clk);
    hv_set = 1'b0; reg_wr = 1'b0;
    chk("R7 old value refuses", int'(hv_en), 0);
    chk("R7 violation", int'(prot_violation), 1);

    // R8 granted enable revoked two edges after the write strobe
    try_req(NFIELD - 1, 16, 1'b0, 1'b0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = RADDR; reg_wdata = DATA_W'(2 << 1);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R8 still on after write edge", int'(hv_en), 1);
    @(negedge clk);
    chk("R8 cleared next edge", int'(hv_en), 0);
    chk("R8 no violation on revoke", int'(prot_violation), 0);

    // R9 clear wins over set, and clear alone
    wr_reg(NFIELD - 1, int'(RADDR));
    try_req(NFIELD - 1, 5, 1'b0, 1'b0);
    @(negedge clk); hv_clr = 1'b1;
    @(negedge clk); hv_clr = 1'b0;
    chk("R9 clear", int'(hv_en), 0);
    @(negedge clk); hv_set = 1'b1; hv_clr = 1'b1; flash_addr = 10'd5;
    @(negedge clk); hv_set = 1'b0; hv_clr = 1'b0;
    chk("R9 clear priority", int'(hv_en), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule